// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog timer for a low-frequency always-on clock domain. Software reaches it through a small 32-bit register port. A 31-bit counter advances on a tick-enable strobe while the block is enabled. A right-shifted view of the counter is compared with a 16-bit threshold. When the shifted view reaches the threshold, a sticky pending flag is set. That flag drives the interrupt line and can also request a system reset.

Every register that alters the timer is guarded. A write to one of them only takes effect if a magic key word was written just before it. Each accepted guarded write uses up the key, so every change needs its own key. Software keeps the timer from firing by writing a second magic word to the feed register, which clears the counter. Both magic words are parameters of the module.

Top module: `keyed_wdog`

## Requirements
- R1: After reset the config register reads 0, the compare register reads 0xBEEF, the key register reads 0, the counter reads 0, and both `irq_out` and `wdt_reset_req` are low.
- R2: The unlock flag is set by a write of `KEY_WORD` to offset 0x1C, and a read of 0x1C returns the flag in bit 0. A write of any other value to 0x1C leaves the flag unchanged.
- R3: While the flag is clear, writes to config (0x00), count (0x08), feed (0x18) and compare (0x20) change nothing.
- R4: An accepted write to any of those four offsets clears the unlock flag. This includes a feed write with the wrong value. A write to the scaled-count offset 0x10 changes nothing and leaves the flag as it was.
- R5: The counter is 31 bits wide. A count write loads data bits [30:0], and bit 31 of a count read is always 0.
- R6: An unlocked write of `FEED_WORD` to 0x18 clears the counter. Reads of 0x18 return 0.
- R7: The counter adds one on each cycle with `tick_en` high, but only when config bit 12 is set, or when config bit 13 is set and `core_awake` is high. Otherwise it holds.
- R8: A read of 0x10 returns the counter shifted right by the scale field, config bits [3:0].
- R9: A match occurs in any cycle where the low 16 bits of the scaled count are at least the compare value. A match sets the pending flag, config bit 28, on the next edge. `irq_out` follows the flag, and only an unlocked config write clears it.
- R10: With config bit 9 set, a match clears the counter on the next edge.
- R11: With config bit 8 set, `wdt_reset_req` is high for exactly one cycle, in the cycle after a match begins.
- R12: Config reads return only bits [3:0], 8, 9, 12, 13 and 28. The other bits read as 0. Bus reads appear on `bus_rdata` one cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on domain clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Counter advance strobe |
| core_awake | input | 1 | High while the core runs |
| bus_valid | input | 1 | Register access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_out | output | 1 | Pending interrupt |
| wdt_reset_req | output | 1 | One-cycle reset request |

## Verification
A lock flag stuck high would let a second guarded write land without a new key. That shows up on the very next readback of the compare or count register. A wrong counter or shift shows up on the next read of 0x08 or 0x10. A wrong compare path shows up one edge after the threshold is crossed: `irq_out` or `wdt_reset_req` is missing, early, or too long. The bench sweeps random counts and scales, and targets each of these timing points directly.

// File: rtl/keyed_wdog_pkg.sv
package keyed_wdog_pkg;
  localparam int ADDR_W = 6;
  localparam logic [ADDR_W-1:0] OFS_CFG  = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_CNT  = 6'h08;
  localparam logic [ADDR_W-1:0] OFS_SCL  = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_FEED = 6'h18;
  localparam logic [ADDR_W-1:0] OFS_KEY  = 6'h1C;
  localparam logic [ADDR_W-1:0] OFS_CMP  = 6'h20;
  localparam int B_RSTEN = 8;
  localparam int B_ZCMP  = 9;
  localparam int B_ALW   = 12;
  localparam int B_AWK   = 13;
  localparam int B_PEND  = 28;

  function automatic logic is_guarded(input logic [ADDR_W-1:0] a);
    return (a == OFS_CFG) || (a == OFS_CNT) || (a == OFS_FEED) || (a == OFS_CMP);
  endfunction
endpackage

// File: rtl/wdog_unlock.sv
module wdog_unlock import keyed_wdog_pkg::*; #(
  parameter int          DATA_W   = 32,
  parameter logic [31:0] KEY_WORD = 32'h0051_F15E
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              unlock_q,
  output logic              accept
);
  logic key_hit;
  logic guarded_wr;

  assign guarded_wr = wr_stb && is_guarded(addr);
  assign key_hit    = wr_stb && (addr == OFS_KEY) && (wdata == DATA_W'(KEY_WORD));
  assign accept     = guarded_wr && unlock_q;

  always_ff @(posedge clk) begin
    if (rst) unlock_q <= 1'b0;
    else if (accept) unlock_q <= 1'b0;
    else if (key_hit) unlock_q <= 1'b1;
  end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 31
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             clear,
  input  logic             advance,
  output logic [CNT_W-1:0] cnt_q
);
  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (clear) cnt_q <= '0;
    else if (advance) cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/wdog_compare.sv
module wdog_compare #(
  parameter int CNT_W   = 31,
  parameter int CMP_W   = 16,
  parameter int SCALE_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [CNT_W-1:0]   cnt,
  input  logic [SCALE_W-1:0] scale,
  input  logic [CMP_W-1:0]   cmp,
  output logic [CNT_W-1:0]   scaled,
  output logic               match,
  output logic               match_new
);
  logic match_q;

  assign scaled    = cnt >> scale;
  assign match     = scaled[CMP_W-1:0] >= cmp;
  assign match_new = match && !match_q;

  always_ff @(posedge clk) begin
    if (rst) match_q <= 1'b0;
    else match_q <= match;
  end
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog import keyed_wdog_pkg::*; #(
  parameter int          DATA_W    = 32,
  parameter int          CNT_W     = 31,
  parameter int          CMP_W     = 16,
  parameter int          SCALE_W   = 4,
  parameter logic [31:0] KEY_WORD  = 32'h0051_F15E,
  parameter logic [31:0] FEED_WORD = 32'h0D09_F00D,
  parameter logic [15:0] CMP_INIT  = 16'hBEEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              core_awake,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_out,
  output logic              wdt_reset_req
);
  logic               wr_stb, rd_stb, accept, unlock_q;
  logic               cfg_wr, cnt_wr, feed_hit, cmp_wr;
  logic [SCALE_W-1:0] scale_q;
  logic               rst_en_q, zero_cmp_q, run_alw_q, run_awk_q, pend_q;
  logic [CMP_W-1:0]   cmp_q;
  logic [CNT_W-1:0]   cnt_q, scaled;
  logic               match, match_new, run;
  logic [DATA_W-1:0]  rd_mux, cfg_word;

  assign wr_stb = bus_valid && bus_write;
  assign rd_stb = bus_valid && !bus_write;

  wdog_unlock #(.DATA_W(DATA_W), .KEY_WORD(KEY_WORD)) u_lock (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .addr(bus_addr),
    .wdata(bus_wdata), .unlock_q(unlock_q), .accept(accept)
  );

  assign cfg_wr   = accept && (bus_addr == OFS_CFG);
  assign cnt_wr   = accept && (bus_addr == OFS_CNT);
  assign cmp_wr   = accept && (bus_addr == OFS_CMP);
  assign feed_hit = accept && (bus_addr == OFS_FEED) && (bus_wdata == DATA_W'(FEED_WORD));
  assign run      = tick_en && (run_alw_q || (run_awk_q && core_awake));

  wdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .load(cnt_wr), .load_val(bus_wdata[CNT_W-1:0]),
    .clear(feed_hit || (match && zero_cmp_q)), .advance(run), .cnt_q(cnt_q)
  );

  wdog_compare #(.CNT_W(CNT_W), .CMP_W(CMP_W), .SCALE_W(SCALE_W)) u_cmp (
    .clk(clk), .rst(rst), .cnt(cnt_q), .scale(scale_q), .cmp(cmp_q),
    .scaled(scaled), .match(match), .match_new(match_new)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      scale_q    <= '0;
      rst_en_q   <= 1'b0;
      zero_cmp_q <= 1'b0;
      run_alw_q  <= 1'b0;
      run_awk_q  <= 1'b0;
      pend_q     <= 1'b0;
      cmp_q      <= CMP_W'(CMP_INIT);
      irq_out    <= 1'b0;
      wdt_reset_req <= 1'b0;
    end else begin
      if (cfg_wr) begin
        scale_q    <= bus_wdata[SCALE_W-1:0];
        rst_en_q   <= bus_wdata[B_RSTEN];
        zero_cmp_q <= bus_wdata[B_ZCMP];
        run_alw_q  <= bus_wdata[B_ALW];
        run_awk_q  <= bus_wdata[B_AWK];
      end
      if (cmp_wr) cmp_q <= bus_wdata[CMP_W-1:0];
      pend_q        <= (cfg_wr ? bus_wdata[B_PEND] : pend_q) || match;
      irq_out       <= (cfg_wr ? bus_wdata[B_PEND] : pend_q) || match;
      wdt_reset_req <= match_new && rst_en_q;
    end
  end

  always_comb begin
    cfg_word = '0;
    cfg_word[SCALE_W-1:0] = scale_q;
    cfg_word[B_RSTEN] = rst_en_q;
    cfg_word[B_ZCMP]  = zero_cmp_q;
    cfg_word[B_ALW]   = run_alw_q;
    cfg_word[B_AWK]   = run_awk_q;
    cfg_word[B_PEND]  = pend_q;
    case (bus_addr)
      OFS_CFG: rd_mux = cfg_word;
      OFS_CNT: rd_mux = DATA_W'(cnt_q);
      OFS_SCL: rd_mux = DATA_W'(scaled);
      OFS_KEY: rd_mux = DATA_W'(unlock_q);
      OFS_CMP: rd_mux = DATA_W'(cmp_q);
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (rd_stb) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/keyed_wdog_chk.sv
module keyed_wdog_chk import keyed_wdog_pkg::*; #(
  parameter int CNT_W = 31,
  parameter int CMP_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              irq_out,
  input logic              wdt_reset_req,
  input logic              unlock_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [CMP_W-1:0]  cmp_q,
  input logic              rst_en_q,
  input logic              match,
  input logic              run
);
  logic wr;
  assign wr = bus_valid && bus_write;

  p_locked_cmp_r3: assert property (@(posedge clk) disable iff (rst)
    (wr && bus_addr == OFS_CMP && !unlock_q) |=> $stable(cmp_q));
  p_key_used_r4: assert property (@(posedge clk) disable iff (rst)
    (wr && is_guarded(bus_addr) && unlock_q) |=> !unlock_q);
  p_count_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!run && !match && !(wr && (bus_addr == OFS_CNT || bus_addr == OFS_FEED))) |=> $stable(cnt_q));
  p_match_irq_r9: assert property (@(posedge clk) disable iff (rst)
    match |=> irq_out);
  p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (irq_out && !(wr && bus_addr == OFS_CFG)) |=> irq_out);
  p_req_gated_r11: assert property (@(posedge clk) disable iff (rst)
    wdt_reset_req |-> $past(rst_en_q));
  p_req_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    wdt_reset_req |=> !wdt_reset_req);
endmodule

bind keyed_wdog keyed_wdog_chk #(.CNT_W(CNT_W), .CMP_W(CMP_W)) u_chk (
  .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .irq_out(irq_out), .wdt_reset_req(wdt_reset_req),
  .unlock_q(unlock_q), .cnt_q(cnt_q), .cmp_q(cmp_q), .rst_en_q(rst_en_q),
  .match(match), .run(run)
);

// File: tb/sim_keyed_wdog.sv
module sim_keyed_wdog;
  localparam logic [31:0] KEY  = 32'h0051_F15E;
  localparam logic [31:0] FEED = 32'h0D09_F00D;
  localparam logic [5:0] A_CFG = 6'h00, A_CNT = 6'h08, A_SCL = 6'h10,
                         A_FEED = 6'h18, A_KEY = 6'h1C, A_CMP = 6'h20;

  logic clk = 1'b0, rst = 1'b1, tick_en = 1'b0, core_awake = 1'b0;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [5:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq_out, wdt_reset_req;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  keyed_wdog #(.KEY_WORD(KEY), .FEED_WORD(FEED), .CMP_INIT(16'hBEEF)) u0 (
    .clk(clk), .rst(rst), .tick_en(tick_en), .core_awake(core_awake),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out),
    .wdt_reset_req(wdt_reset_req));

  function automatic logic [31:0] exp_scaled(input logic [31:0] v, input int sc);
    return {1'b0, v[30:0]} >> sc;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    d = bus_rdata;
  endtask

  task automatic uwr(input logic [5:0] a, input logic [31:0] d);
    wr(A_KEY, KEY);
    wr(a, d);
  endtask

  task automatic tick_n(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic [31:0] v;
    int sc;
    v = $urandom(32'd7);
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset values
    rd(A_CFG, d); chk("R1 cfg", d, 32'h0);
    rd(A_CMP, d); chk("R1 cmp", d, 32'h0000_BEEF);
    rd(A_KEY, d); chk("R1 key", d, 32'h0);
    rd(A_CNT, d); chk("R1 count", d, 32'h0);
    chk("R1 irq", {31'b0, irq_out}, 32'h0);
    chk("R1 req", {31'b0, wdt_reset_req}, 32'h0);

    // R3: locked write ignored; R2 wrong key
    wr(A_CMP, 32'h5); rd(A_CMP, d); chk("R3 locked cmp", d, 32'h0000_BEEF);
    wr(A_KEY, 32'h1234); rd(A_KEY, d); chk("R2 wrong key", d, 32'h0);
    wr(A_KEY, KEY); rd(A_KEY, d); chk("R2 key set", d, 32'h1);
    wr(A_CMP, 32'h20); rd(A_CMP, d); chk("R4 cmp accepted", d, 32'h20);
    rd(A_KEY, d); chk("R4 key consumed", d, 32'h0);

    // R5 count width; R4 wrong feed consumes; R6 feed
    uwr(A_CNT, 32'h8000_0005); rd(A_CNT, d); chk("R5 bit31 dropped", d, 32'h5);
    uwr(A_FEED, 32'h1111); rd(A_CNT, d); chk("R6 wrong feed keeps count", d, 32'h5);
    rd(A_KEY, d); chk("R4 wrong feed consumes key", d, 32'h0);
    uwr(A_FEED, FEED); rd(A_CNT, d); chk("R6 feed clears", d, 32'h0);
    rd(A_FEED, d); chk("R6 feed reads zero", d, 32'h0);

    // R4 scaled-count write ignored, key kept
    uwr(A_SCL, 32'h77); rd(A_KEY, d); chk("R4 scaled write keeps key", d, 32'h1);
    rd(A_SCL, d); chk("R4 scaled write ignored", d, 32'h0);

    // R7 counting modes
    wr(A_CFG, 32'h0000_1000); tick_n(10);
    rd(A_CNT, d); chk("R7 run always", d, 32'd10);
    uwr(A_CFG, 32'h0); tick_n(5);
    rd(A_CNT, d); chk("R7 disabled holds", d, 32'd10);
    uwr(A_CFG, 32'h0000_2000); core_awake = 1'b0; tick_n(5);
    rd(A_CNT, d); chk("R7 awake mode core asleep", d, 32'd10);
    core_awake = 1'b1; tick_n(4);
    rd(A_CNT, d); chk("R7 awake mode core awake", d, 32'd14);
    core_awake = 1'b0;

    // R9 / R11 match with scale 1, reset enabled
    uwr(A_FEED, FEED); uwr(A_CMP, 32'h4); uwr(A_CFG, 32'h0000_1101);
    tick_n(8);
    chk("R11 no req before match edge", {31'b0, wdt_reset_req}, 32'h0);
    chk("R9 no irq before match edge", {31'b0, irq_out}, 32'h0);
    @(negedge clk);
    chk("R11 req pulse", {31'b0, wdt_reset_req}, 32'h1);
    chk("R9 irq set", {31'b0, irq_out}, 32'h1);
    @(negedge clk);
    chk("R11 req one cycle", {31'b0, wdt_reset_req}, 32'h0);
    rd(A_SCL, d); chk("R8 scaled count", d, 32'd4);
    rd(A_CFG, d); chk("R9 pending bit", d, 32'h1000_1101);

    // R9 sticky
    wr(A_CFG, 32'h0); chk("R3 locked cfg keeps irq", {31'b0, irq_out}, 32'h1);
    uwr(A_CFG, 32'h0); chk("R9 match re-sets pending", {31'b0, irq_out}, 32'h1);
    uwr(A_FEED, FEED); uwr(A_CFG, 32'h0);
    chk("R9 cleared by cfg write", {31'b0, irq_out}, 32'h0);

    // R10 zero on compare
    uwr(A_CMP, 32'h3); uwr(A_CFG, 32'h0000_1200);
    tick_n(3);
    rd(A_CNT, d); chk("R10 count cleared", d, 32'h0);
    chk("R10 irq", {31'b0, irq_out}, 32'h1);
    chk("R11 no req without enable", {31'b0, wdt_reset_req}, 32'h0);

    // R12 reserved bits
    uwr(A_CFG, 32'hFFFF_FFFF); rd(A_CFG, d); chk("R12 reserved bits", d, 32'h1000_330F);
    uwr(A_CFG, 32'h0); uwr(A_FEED, FEED); uwr(A_CFG, 32'h0);
    chk("R9 clear", {31'b0, irq_out}, 32'h0);

    // R8 random sweep
    uwr(A_CMP, 32'hFFFF);
    for (int i = 0; i < 40; i++) begin
      v = $urandom;
      sc = int'($urandom % 16);
      uwr(A_CNT, v);
      uwr(A_CFG, 32'(sc));
      rd(A_CNT, d); chk("R5 random count", d, {1'b0, v[30:0]});
      rd(A_SCL, d); chk("R8 random scaled", d, exp_scaled(v, sc));
    end

    finish_run();
  end
endmodule